// File: doc/BRIEF.md
# Start/Done Transaction Sequencer

This block is the control shell around a small fixed-latency arithmetic datapath. It adds two operands to each other, and it also adds them to a running value that is passed in on one port and handed back, updated, on another. A requester asks for work by raising a start request. The block answers with the usual run-control signals: busy/idle, completion, and readiness for new operands. Each accepted start runs exactly one transaction.

The datapath latency is a parameter, so the same shell can sequence a datapath that needs several cycles to settle. The operand ports carry no handshake of their own. The block copies them on the clock edge that accepts the transaction. The requester keeps start asserted until it sees ready. If start is still high in the ready cycle, the next transaction is chained with no idle cycle between the two. If start has dropped, the block goes back to rest.

Top module: `accel_seq`

## Requirements
- R1: After reset, idle_o is 1 and done_o, ready_o and sum_vld_o are 0. They stay that way until start_i is sampled high.
- R2: When start_i is sampled high on a rising edge while idle_o is 1, idle_o is 0 from the next cycle on.
- R3: done_o is high for exactly one cycle. It comes LAT rising edges after the accepting edge, with the accepting edge counted as the first.
- R4: ready_o is high in exactly the cycles where done_o is high. It is never high before the first transaction has been accepted.
- R5: If start_i is low in a done cycle, the block stops. idle_o is 1 in the next cycle and stays 1 while start_i stays low, with no further done_o.
- R6: If start_i is high in a done cycle, that edge accepts a new transaction. idle_o stays 0, and the next done_o follows LAT edges later.
- R7: During done_o, ret_o equals (a_i + b_i) modulo 2^DW, using the operands sampled on the accepting edge.
- R8: During done_o, sum_o equals (a_i + b_i + sum_i) modulo 2^DW, and sum_vld_o is high. sum_vld_o is low in every other cycle.
- R9: Operand values are sampled only on the accepting edge. Changes to a_i, b_i or sum_i after that edge do not affect the results of the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Transaction request; held high until ready_o |
| a_i | input | DW | First operand, no handshake |
| b_i | input | DW | Second operand, no handshake |
| sum_i | input | DW | Current accumulated value |
| done_o | output | 1 | One-cycle completion pulse |
| idle_o | output | 1 | High while no transaction is running |
| ready_o | output | 1 | New operands may be applied (same cycle as done_o) |
| ret_o | output | DW | Return value a + b, valid with done_o |
| sum_o | output | DW | Updated accumulated value |
| sum_vld_o | output | 1 | Strobe marking sum_o valid |

## Verification
A wrong cycle counter shows up at the very first transaction: done_o arrives earlier or later than LAT edges after acceptance. A stale busy flag shows up one cycle after a done with start low, as idle_o failing to rise, or during a chain, as a one-cycle idle gap. A wrong operand capture shows in ret_o and sum_o at the next done_o. This happens either because the block captured at the wrong edge or because it did not capture and followed the live ports. The bench catches that case by scrambling the operand ports mid-transaction.

// File: rtl/accel_seq.sv
module accel_seq #(
  parameter int DW  = 8,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] sum_i,
  output logic          done_o,
  output logic          idle_o,
  output logic          ready_o,
  output logic [DW-1:0] ret_o,
  output logic [DW-1:0] sum_o,
  output logic          sum_vld_o
);

  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(LAT - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] a_q, b_q, s_q;
  logic          last;

  assign last = busy_q && (cnt_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      s_q    <= '0;
    end else if (!busy_q || last) begin
      busy_q <= start_i;
      cnt_q  <= '0;
      if (start_i) begin
        a_q <= a_i;
        b_q <= b_i;
        s_q <= sum_i;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ret_o     = a_q + b_q;
  assign sum_o     = ret_o + s_q;
  assign done_o    = last;
  assign ready_o   = last;
  assign sum_vld_o = last;
  assign idle_o    = !busy_q;

  a_r1_no_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> !done_o);
  a_r2_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && start_i) |=> !idle_o);
  a_r5_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> idle_o);
  a_r6_chain_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> !idle_o);
  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_o && !done_o) |=> ($stable(ret_o) && $stable(sum_o)));

endmodule

// File: tb/accel_seq_tb.sv
module accel_seq_tb;
  localparam int DW  = 8;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [DW-1:0] a_i, b_i, sum_i;
  logic          done_o, idle_o, ready_o, sum_vld_o;
  logic [DW-1:0] ret_o, sum_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  accel_seq #(.DW(DW), .LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .a_i(a_i), .b_i(b_i), .sum_i(sum_i),
    .done_o(done_o), .idle_o(idle_o), .ready_o(ready_o),
    .ret_o(ret_o), .sum_o(sum_o), .sum_vld_o(sum_vld_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic txn(input logic [DW-1:0] a, input logic [DW-1:0] b,
                     input logic [DW-1:0] s, input bit hold, input bit scramble);
    logic [DW-1:0] exp_ret, exp_sum;
    int n;
    exp_ret = a + b;
    exp_sum = a + b + s;
    a_i = a; b_i = b; sum_i = s; start_i = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (scramble) begin a_i = ~a; b_i = a ^ b; sum_i = s + 8'd37; end
      chk(idle_o == 1'b0, "R2/R6 idle low while busy", int'(idle_o), 0);
      if (!done_o) chk(!sum_vld_o && !ready_o, "R8 strobe off before done", int'(sum_vld_o), 0);
    end while (!done_o && n < 50);
    chk(n == LAT, "R3 latency", n, LAT);
    chk(ready_o == 1'b1, "R4 ready with done", int'(ready_o), 1);
    chk(ret_o == exp_ret, scramble ? "R9 ret after scramble" : "R7 ret", int'(ret_o), int'(exp_ret));
    chk(sum_o == exp_sum && sum_vld_o, scramble ? "R9 sum after scramble" : "R8 sum", int'(sum_o), int'(exp_sum));
    if (!hold) begin
      start_i = 1'b0;
      @(negedge clk);
      chk(idle_o == 1'b1, "R5 idle after done", int'(idle_o), 1);
      chk(done_o == 1'b0, "R3 done single cycle", int'(done_o), 0);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] vals [5];
    vals = '{8'd0, 8'd1, 8'd127, 8'd128, 8'd255};
    rst_n = 1'b0; start_i = 1'b0; a_i = '0; b_i = '0; sum_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(idle_o && !done_o && !ready_o && !sum_vld_o, "R1 R4 reset state", int'(idle_o), 1);
    end
    foreach (vals[i]) foreach (vals[j])
      txn(vals[i], vals[j], vals[(i + j) % 5] ^ 8'h5a, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(idle_o && !done_o, "R5 stays idle", int'(idle_o), 1);
    end
    txn(8'd10, 8'd20, 8'd30, 1'b1, 1'b0);
    txn(8'd200, 8'd100, 8'd250, 1'b1, 1'b0);
    txn(8'd3, 8'd4, 8'd5, 1'b1, 1'b1);
    txn(8'd255, 8'd255, 8'd255, 1'b0, 1'b0);
    txn(8'd66, 8'd77, 8'd88, 1'b0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule